// File: doc/BRIEF.md
# Microprogrammed Sequencer for an 8-bit Accumulator CPU

This block is the control section of a small accumulator machine. It holds a 4-bit microstep counter and turns the current opcode, the status flags and that counter into a 29-line control word for the datapath. The control store is pure combinational logic. It has no memory array. Flag-dependent behaviour is part of the decode: conditional jumps and the wait for input data are chosen by the flag inputs in the same cycle.

Every instruction begins with a fetch of its first byte. Instructions with a wide operand fetch a second byte. The body then runs, and a step-clear line returns the counter to zero on the following clock. When the halt line is active, the counter holds its value. A halt on the top opcode therefore freezes the machine. The input stall releases as soon as the ready flag rises. Some lines are inverted at the port, so the datapath sees them active-low.

Top module: `ucode_sequencer`

## Requirements
- R1: Synchronous reset sets `ustep` to 0. Reset applied in the middle of an instruction also returns `ustep` to 0 on that clock.
- R2: Control bit positions: 0 halt, 1 acc load, 2 acc drive, 3 operand-B load, 4 operand-B drive, 5 PC load, 6 output load, 7 PC increment, 8 PC drive, 9 index load, 10 index drive, 11 index increment, 12 memory write, 13 memory drive, 14 MAR load, 15 program-memory address load, 16 IR short drive, 17 IR wide drive, 18 and 19 IR spare selects, 20 program-memory drive, 21 input drive, 22 IR low load, 23 IR high load, 24 flags load, 25 ALU drive, 26 ALU subtract, 27 step clear, 28 input request. Bits 0,2,4,5,8,9,10,12,13,19,20,21,24,25 are active-low at the port and all others are active-high.
- R3: In step 0 of every opcode, the PC drive and MAR load lines are active. In step 1, the memory drive, IR low load and PC increment lines are active.
- R4: Wide-operand opcodes repeat the step-0 word in step 2 and use memory drive, IR high load and PC increment in step 3. Their body starts at step 4. For all other opcodes the body starts at step 2. Wide-operand opcodes: 2,3,6,9,10,12,14,15,19,20,25,28 and 31 to 44.
- R5: The step after the last body word carries step clear, and `ustep` is 0 after the next clock. Otherwise `ustep` advances by one per clock.
- R6: Flags: bit 0 zero (Z), bit 1 carry (C), bit 2 input ready, bit 3 spare with no effect. Opcodes 33 to 44 are conditional jumps in pairs: an odd opcode is the immediate form and the following even opcode is the address form. The pairs, in order, are taken on Z, not Z, C and not Z, not C, C or Z, and not C or Z.
- R7: A jump that is not taken clears at step 4. A taken immediate jump drives IR wide with PC load at step 4 and clears at step 5. A taken address jump drives IR wide with MAR load at step 4, memory drive with PC load at step 5, and clears at step 6.
- R8: Opcodes 24, 25 and 26 assert input request at steps 2, 5 and 3. While input ready is 0, that word also carries halt and `ustep` holds. Once ready is 1, the halt line drops and `ustep` advances on the next clock.
- R9: Opcode 63 asserts halt at step 2 and stays there. Opcodes 0 and 45 to 62 clear at step 2.
- R10: An ALU step drives ALU, loads acc and loads flags together. Opcodes 13 to 17 add and opcodes 18 to 22 also assert ALU subtract. Each form loads operand B one step earlier.
- R11: In any step, at most one bus driver is active: acc, operand-B, PC, index, memory, IR short, IR wide, program memory, input or ALU.
- R12: For every opcode and every flag value, the step that carries step clear matches the per-opcode body length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active-high |
| opcode | input | 6 | Opcode from the instruction register |
| flags | input | 4 | Status flags {spare, ready, carry, zero} |
| ustep | output | 4 | Current microstep |
| ctrl | output | 29 | Control word, mixed polarity |

## Verification
The input instructions raise the input-request line and the halt line in the same microstep. That word must hold the counter and still request data. The bench provokes this by running opcodes 24, 25 and 26 with the ready flag clear and clocking several times at the stall step. It then checks that both lines show at their own polarity and that `ustep` has not moved. It then raises ready in the middle of the stall and checks that halt drops in the same cycle and that the counter moves to the next body step on the next clock.

// File: rtl/ucode_sequencer.sv
module ucode_sequencer #(
  parameter int OPW = 6,
  parameter int SW  = 4,
  parameter int FW  = 4,
  parameter int CW  = 29
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  input  logic [FW-1:0]  flags,
  output logic [SW-1:0]  ustep,
  output logic [CW-1:0]  ctrl
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] HALT = ONE << 0,  ACC_LD = ONE << 1,  ACC_DRV = ONE << 2;
  localparam logic [CW-1:0] OPB_LD = ONE << 3, OPB_DRV = ONE << 4, PC_LD = ONE << 5;
  localparam logic [CW-1:0] OUT_LD = ONE << 6, PC_INC = ONE << 7,  PC_DRV = ONE << 8;
  localparam logic [CW-1:0] IDX_LD = ONE << 9, IDX_DRV = ONE << 10, IDX_INC = ONE << 11;
  localparam logic [CW-1:0] MEM_WR = ONE << 12, MEM_DRV = ONE << 13, MAR_LD = ONE << 14;
  localparam logic [CW-1:0] PMA_LD = ONE << 15, IRS = ONE << 16, IRW = ONE << 17;
  localparam logic [CW-1:0] IRM1 = ONE << 19, PM_DRV = ONE << 20, INP_DRV = ONE << 21;
  localparam logic [CW-1:0] IRLO_LD = ONE << 22, IRHI_LD = ONE << 23, FLG_LD = ONE << 24;
  localparam logic [CW-1:0] ALU_DRV = ONE << 25, ALU_SUB = ONE << 26, CLR = ONE << 27;
  localparam logic [CW-1:0] INP_REQ = ONE << 28;
  localparam logic [CW-1:0] LOW_MASK = HALT | ACC_DRV | OPB_DRV | PC_LD | PC_DRV | IDX_LD
    | IDX_DRV | MEM_WR | MEM_DRV | IRM1 | PM_DRV | INP_DRV | FLG_LD | ALU_DRV;
  localparam logic [CW-1:0] F0  = PC_DRV | MAR_LD;
  localparam logic [CW-1:0] F1  = MEM_DRV | IRLO_LD | PC_INC;
  localparam logic [CW-1:0] F1H = MEM_DRV | IRHI_LD | PC_INC;
  localparam logic [CW-1:0] ALU = ALU_DRV | ACC_LD | FLG_LD;
  localparam logic [CW-1:0] DRIVERS = ACC_DRV | OPB_DRV | PC_DRV | IDX_DRV | MEM_DRV | IRS
    | IRW | PM_DRV | INP_DRV | ALU_DRV;
  localparam logic [SW-1:0] SHORT_BASE = SW'(2);
  localparam logic [SW-1:0] LONG_BASE  = SW'(4);

  logic [CW-1:0] act, b0, b1, b2, rq;
  logic [SW-1:0] n, base, k;
  logic [OPW-1:0] jsel;
  logic lng, take, halt, clr;
  logic z, c, rdy, unused_spare;

  assign z = flags[0];
  assign c = flags[1];
  assign rdy = flags[2];
  assign unused_spare = flags[3];
  assign jsel = opcode - OPW'(33);
  assign rq = INP_REQ | (rdy ? '0 : HALT);

  always_comb begin
    case (jsel[3:1])
      3'd0: take = z;
      3'd1: take = !z;
      3'd2: take = c && !z;
      3'd3: take = !c;
      3'd4: take = c || z;
      3'd5: take = !c || z;
      default: take = 1'b0;
    endcase
  end

  always_comb begin
    lng = 1'b0; n = '0; b0 = '0; b1 = '0; b2 = '0;
    case (opcode)
      6'd1:  begin n = 1; b0 = IRS | ACC_LD; end
      6'd2:  begin lng = 1; n = 1; b0 = IRW | ACC_LD; end
      6'd3:  begin lng = 1; n = 2; b0 = IRW | MAR_LD; b1 = MEM_DRV | ACC_LD; end
      6'd4:  begin n = 1; b0 = IDX_DRV | ACC_LD; end
      6'd5:  begin n = 2; b0 = IDX_DRV | MAR_LD; b1 = MEM_DRV | ACC_LD; end
      6'd6:  begin lng = 1; n = 2; b0 = IRW | MAR_LD; b1 = ACC_DRV | MEM_WR; end
      6'd7:  begin n = 2; b0 = IDX_DRV | MAR_LD; b1 = ACC_DRV | MEM_WR; end
      6'd8:  begin n = 1; b0 = IRS | IDX_LD; end
      6'd9:  begin lng = 1; n = 1; b0 = IRW | IDX_LD; end
      6'd10: begin lng = 1; n = 2; b0 = IRW | MAR_LD; b1 = MEM_DRV | IDX_LD; end
      6'd11: begin n = 1; b0 = ACC_DRV | IDX_LD; end
      6'd12: begin lng = 1; n = 2; b0 = IRW | MAR_LD; b1 = IDX_DRV | MEM_WR; end
      6'd13: begin n = 2; b0 = IRS | OPB_LD; b1 = ALU; end
      6'd14: begin lng = 1; n = 2; b0 = IRW | OPB_LD; b1 = ALU; end
      6'd15: begin lng = 1; n = 3; b0 = IRW | MAR_LD; b1 = MEM_DRV | OPB_LD; b2 = ALU; end
      6'd16: begin n = 2; b0 = IDX_DRV | OPB_LD; b1 = ALU; end
      6'd17: begin n = 3; b0 = IDX_DRV | MAR_LD; b1 = MEM_DRV | OPB_LD; b2 = ALU; end
      6'd18: begin n = 2; b0 = IRS | OPB_LD; b1 = ALU | ALU_SUB; end
      6'd19: begin lng = 1; n = 2; b0 = IRW | OPB_LD; b1 = ALU | ALU_SUB; end
      6'd20: begin lng = 1; n = 3; b0 = IRW | MAR_LD; b1 = MEM_DRV | OPB_LD; b2 = ALU | ALU_SUB; end
      6'd21: begin n = 2; b0 = IDX_DRV | OPB_LD; b1 = ALU | ALU_SUB; end
      6'd22: begin n = 3; b0 = IDX_DRV | MAR_LD; b1 = MEM_DRV | OPB_LD; b2 = ALU | ALU_SUB; end
      6'd23: begin n = 1; b0 = IDX_INC; end
      6'd24: begin n = 2; b0 = rq; b1 = INP_DRV | ACC_LD; end
      6'd25: begin lng = 1; n = 3; b0 = IRW | MAR_LD; b1 = rq; b2 = INP_DRV | MEM_WR; end
      6'd26: begin n = 3; b0 = IDX_DRV | MAR_LD; b1 = rq; b2 = INP_DRV | MEM_WR; end
      6'd27: begin n = 1; b0 = ACC_DRV | OUT_LD; end
      6'd28: begin lng = 1; n = 2; b0 = IRW | MAR_LD; b1 = MEM_DRV | OUT_LD; end
      6'd29: begin n = 2; b0 = IDX_DRV | MAR_LD; b1 = MEM_DRV | OUT_LD; end
      6'd30: begin n = 2; b0 = IDX_DRV | PMA_LD; b1 = PM_DRV | ACC_LD; end
      6'd31: begin lng = 1; n = 1; b0 = IRW | PC_LD; end
      6'd32: begin lng = 1; n = 2; b0 = IRW | MAR_LD; b1 = MEM_DRV | PC_LD; end
      6'd63: begin n = 1; b0 = HALT; end
      default: begin
        if (opcode >= 6'd33 && opcode <= 6'd44) begin
          lng = 1;
          if (take && opcode[0]) begin
            n = 1; b0 = IRW | PC_LD;
          end else if (take) begin
            n = 2; b0 = IRW | MAR_LD; b1 = MEM_DRV | PC_LD;
          end
        end
      end
    endcase
  end

  assign base = lng ? LONG_BASE : SHORT_BASE;
  assign k = ustep - base;

  always_comb begin
    if (ustep == SW'(0))              act = F0;
    else if (ustep == SW'(1))         act = F1;
    else if (lng && ustep == SW'(2))  act = F0;
    else if (lng && ustep == SW'(3))  act = F1H;
    else if (k < n) begin
      case (k)
        SW'(0):  act = b0;
        SW'(1):  act = b1;
        default: act = b2;
      endcase
    end
    else if (k == n)                  act = CLR;
    else                              act = '0;
  end

  assign halt = |(act & HALT);
  assign clr  = |(act & CLR);
  assign ctrl = act ^ LOW_MASK;

  always_ff @(posedge clk) begin
    if (rst)       ustep <= '0;
    else if (halt) ustep <= ustep;
    else if (clr)  ustep <= '0;
    else           ustep <= ustep + SW'(1);
  end

  // R5
  step_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[0] == 1'b0 && ctrl[27]) |=> ustep == '0);
  // R5
  step_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl[0] && !ctrl[27]) |=> ustep == $past(ustep) + SW'(1));
  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl[0] |=> $stable(ustep));
  // R11
  one_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0((ctrl ^ LOW_MASK) & DRIVERS));
endmodule

// File: tb/ucode_sequencer_test.sv
`timescale 1ns/100ps
module ucode_sequencer_test;
  localparam int CW = 29;
  typedef logic [CW-1:0] w_t;
  localparam w_t L1 = w_t'(1);
  localparam w_t H_HALT = L1 << 0, H_ACCL = L1 << 1, H_ACCD = L1 << 2, H_OPBL = L1 << 3;
  localparam w_t H_OPBD = L1 << 4, H_PCL = L1 << 5, H_PCI = L1 << 7, H_PCD = L1 << 8;
  localparam w_t H_IDXD = L1 << 10, H_IDXI = L1 << 11, H_MWR = L1 << 12, H_MDRV = L1 << 13;
  localparam w_t H_MAR = L1 << 14, H_PMA = L1 << 15, H_IRS = L1 << 16, H_IRW = L1 << 17;
  localparam w_t H_PMD = L1 << 20, H_INPD = L1 << 21, H_IRLO = L1 << 22, H_IRHI = L1 << 23;
  localparam w_t H_FLG = L1 << 24, H_ALUD = L1 << 25, H_SUB = L1 << 26, H_CLR = L1 << 27;
  localparam w_t H_REQ = L1 << 28;
  localparam w_t INV = H_HALT | H_ACCD | H_OPBD | H_PCL | H_PCD | (L1 << 9) | H_IDXD | H_MWR
    | H_MDRV | (L1 << 19) | H_PMD | H_INPD | H_FLG | H_ALUD;
  localparam w_t DRV = H_ACCD | H_OPBD | H_PCD | H_IDXD | H_MDRV | H_IRS | H_IRW | H_PMD
    | H_INPD | H_ALUD;
  localparam w_t ALUW = H_ALUD | H_ACCL | H_FLG;

  typedef struct packed { logic [5:0] op; logic [3:0] fl; logic [3:0] st; w_t w; } vec_t;
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{6'd0,  4'd0, 4'd1, H_MDRV | H_IRLO | H_PCI},
    '{6'd1,  4'd0, 4'd2, H_IRS | H_ACCL},
    '{6'd3,  4'd0, 4'd5, H_MDRV | H_ACCL},
    '{6'd6,  4'd0, 4'd5, H_ACCD | H_MWR},
    '{6'd13, 4'd0, 4'd3, ALUW},
    '{6'd20, 4'd0, 4'd6, ALUW | H_SUB},
    '{6'd33, 4'd1, 4'd4, H_IRW | H_PCL},
    '{6'd34, 4'd1, 4'd5, H_MDRV | H_PCL},
    '{6'd36, 4'd1, 4'd4, H_CLR},
    '{6'd37, 4'd2, 4'd4, H_IRW | H_PCL},
    '{6'd39, 4'd2, 4'd4, H_CLR},
    '{6'd42, 4'd1, 4'd4, H_IRW | H_MAR},
    '{6'd44, 4'd3, 4'd6, H_CLR},
    '{6'd30, 4'd0, 4'd2, H_IDXD | H_PMA},
    '{6'd24, 4'd4, 4'd2, H_REQ},
    '{6'd2,  4'd8, 4'd3, H_MDRV | H_IRHI | H_PCI},
    '{6'd23, 4'd0, 4'd2, H_IDXI}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [3:0] flags = '0;
  logic [3:0] ustep;
  w_t ctrl;
  int total = 0, bad = 0, cyc = 0, drv_bad = 0;

  ucode_sequencer uut (.clk(clk), .rst(rst), .opcode(opcode), .flags(flags),
    .ustep(ustep), .ctrl(ctrl));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if ((((ctrl ^ INV) & DRV) & (((ctrl ^ INV) & DRV) - w_t'(1))) != '0) drv_bad++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start(input logic [5:0] op, input logic [3:0] fl);
    opcode = op; flags = fl; rst = 1'b1; tick(); rst = 1'b0; #1;
  endtask

  function automatic int body_len(input int op, input logic [3:0] fl);
    logic t;
    case ((op - 33) / 2)
      0: t = fl[0];
      1: t = !fl[0];
      2: t = fl[1] && !fl[0];
      3: t = !fl[1];
      4: t = fl[1] || fl[0];
      default: t = !fl[1] || fl[0];
    endcase
    if (op >= 33 && op <= 44) return t ? ((op % 2 == 1) ? 1 : 2) : 0;
    case (op)
      1, 2, 4, 8, 9, 11, 23, 27, 31, 63: return 1;
      3, 5, 6, 7, 10, 12, 13, 14, 16, 18, 19, 21, 24, 28, 29, 30, 32: return 2;
      15, 17, 20, 22, 25, 26: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic bit is_long(input int op);
    return (op >= 31 && op <= 44) || op == 2 || op == 3 || op == 6 || op == 9 || op == 10
      || op == 12 || op == 14 || op == 15 || op == 19 || op == 20 || op == 25 || op == 28;
  endfunction

  initial begin
    #1;
    tick(); rst = 1'b0; #1;
    // R1 R2 R3: reset state and fetch word polarity
    chk("R1", 64'(ustep), 64'd0);
    chk("R2 R3", 64'(ctrl), 64'((H_PCD | H_MAR) ^ INV));

    // R4 R6 R7 R10 table of vectors
    for (int v = 0; v < NV; v++) begin
      start(VECS[v].op, VECS[v].fl);
      while (ustep != VECS[v].st) tick();
      chk("R4/R6/R7/R10 vector", 64'(ctrl), 64'(VECS[v].w ^ INV));
    end

    // R12 full sweep of end step
    for (int op = 0; op < 64; op++) begin
      for (int f = 0; f < 16; f++) begin
        int got;
        if (op == 63 || (op >= 24 && op <= 26 && f[2] == 1'b0)) continue;
        start(6'(op), 4'(f));
        got = -1;
        for (int t = 0; t < 10; t++) begin
          if (ctrl[27]) begin got = ustep; break; end
          tick();
        end
        chk("R12", 64'(got), 64'((is_long(op) ? 4 : 2) + body_len(op, 4'(f))));
      end
    end
    // R11 at most one driver over all cycles so far
    chk("R11", 64'(drv_bad), 64'd0);

    // R5 clear returns to step 0
    start(6'd0, 4'd0);
    tick(); tick();
    chk("R5 clr", 64'(ctrl[27]), 64'd1);
    tick();
    chk("R5 wrap", 64'(ustep), 64'd0);

    // R8 stall on opcode 25 at step 5
    start(6'd25, 4'd0);
    while (ustep != 4'd5) tick();
    chk("R8 halt low", 64'(ctrl[0]), 64'd0);
    chk("R8 request", 64'(ctrl[28]), 64'd1);
    tick(); tick(); tick();
    chk("R8 hold", 64'(ustep), 64'd5);
    flags = 4'b0100; #1;
    chk("R8 release", 64'(ctrl[0]), 64'd1);
    tick();
    chk("R8 next", 64'(ctrl), 64'((H_INPD | H_MWR) ^ INV));
    start(6'd24, 4'd0);
    tick(); tick(); tick(); tick();
    chk("R8 op24 hold", 64'(ustep), 64'd2);
    start(6'd26, 4'd0);
    tick(); tick(); tick(); tick(); tick();
    chk("R8 op26 hold", 64'(ustep), 64'd3);

    // R9 top opcode halts, NOP range ends early
    start(6'd63, 4'd4);
    tick(); tick(); tick(); tick(); tick();
    chk("R9 halt", 64'(ustep), 64'd2);
    chk("R9 halt line", 64'(ctrl[0]), 64'd0);
    start(6'd50, 4'd0);
    tick(); tick();
    chk("R9 nop", 64'(ctrl[27]), 64'd1);

    // R1 reset mid-instruction
    start(6'd15, 4'd0);
    while (ustep != 4'd5) tick();
    rst = 1'b1; tick(); rst = 1'b0; #1;
    chk("R1 mid", 64'(ustep), 64'd0);

    // R6 spare flag has no effect on a not-taken jump
    start(6'd35, 4'b1001);
    tick(); tick(); tick(); tick();
    chk("R6 spare", 64'(ctrl), 64'(H_CLR ^ INV));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule